// File: doc/BRIEF.md
# PCM Highway Time Slot Assigner

This block moves per-channel voice samples onto and off a time-division-multiplexed PCM highway. A frame sync input and a bit clock split each 8 kHz frame into 8-bit time slots. Four channels are served. Each channel has its own transmit slot, receive slot, coding width (one companded byte or a 16-bit linear word), optional transmit signalling byte and highway select. For each highway the block drives a serial transmit line and an active-low output-enable strobe. The strobe controls an external tristate buffer and is low only while some channel owns the current bit period.

The bit clock is a slow strobe-like input produced in the system clock domain. The block detects its edges and uses the programmed polarity to choose the launch edge for transmit data. Receive data is sampled on the opposite edge. A programmable clock-slot offset shifts slot 0 away from the frame sync bit. Transmit samples come in on parallel per-channel registers and are captured once per frame. Received samples leave on parallel per-channel registers together with a one-cycle valid pulse.

Top module: `pcm_tsa`

## Requirements
- R1: After reset, and until the first frame sync has been taken on a launch edge, every `hwy_oe_n` bit is 1, every `hwy_tx` bit is 0, `rx_valid` is 0 and `rx_sample` is all zero.
- R2: A companded channel whose signalling is disabled owns one slot on its transmit highway. It sends `tx_sample[7:0]`, MSB first, one bit per bit period.
- R3: A linear channel owns two consecutive slots, starting at its transmit slot. It sends `tx_sample[15:8]` and then `tx_sample[7:0]`, MSB first.
- R4: A companded channel with signalling enabled also owns the next slot and sends `tx_sig` there, MSB first. For a linear channel the signalling enable and `tx_sig` have no effect.
- R5: Bit period n of a frame is counted from 0 at the launch edge on which `fsync` is high. It belongs to slot (n − `cfg_clk_slot`) / 8, at bit (n − `cfg_clk_slot`) mod 8. Bit periods before the offset belong to no slot.
- R6: `cfg_tx_fall` = 0 launches transmit data on the rising edge of `bclk`, and 1 launches it on the falling edge. Transmit outputs hold steady through the opposite edge. Receive data is sampled on that opposite edge.
- R7: `hwy_oe_n[h]` is 0 only in bit periods that a transmit-enabled channel selecting highway h owns. At all other times it is 1 and `hwy_tx[h]` is 0.
- R8: When several channels own the same bit period on one highway, the channel with the lowest index drives it.
- R9: A receive-enabled channel shifts in 8 bits (companded) or 16 bits (linear) from its selected highway, starting at its receive slot, MSB first. After the last bit is sampled it presents the word on `rx_sample` with a one-cycle `rx_valid` pulse. A companded word is zero-extended.
- R10: A channel with `cfg_tx_en` = 0 owns no transmit slot. A channel with `cfg_rx_en` = 0 produces no `rx_valid`.
- R11: `tx_sample` and `tx_sig` are captured at the frame-sync launch edge. Changes later in the frame have no effect on that frame's transmit bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Highway bit clock, synchronous level in the clk domain |
| fsync | input | 1 | Frame sync, taken on the launch edge |
| cfg_tx_fall | input | 1 | 1: launch on falling bclk edge, 0: on rising edge |
| cfg_clk_slot | input | OFF_W | Bit offset of slot 0 after the frame sync bit |
| cfg_tx_en | input | NCH | Per-channel transmit enable |
| cfg_rx_en | input | NCH | Per-channel receive enable |
| cfg_linear | input | NCH | Per-channel 16-bit linear coding |
| cfg_sig_en | input | NCH | Per-channel signalling byte enable (companded only) |
| cfg_hwy | input | NCH×HWY_W | Per-channel highway select |
| cfg_tx_slot | input | NCH×SLOT_W | Per-channel transmit slot |
| cfg_rx_slot | input | NCH×SLOT_W | Per-channel receive slot |
| tx_sample | input | NCH×16 | Per-channel transmit sample |
| tx_sig | input | NCH×8 | Per-channel signalling byte |
| hwy_rx | input | NHWY | Receive data line of each highway |
| hwy_tx | output | NHWY | Transmit data line of each highway |
| hwy_oe_n | output | NHWY | Active-low tristate control of each highway |
| rx_sample | output | NCH×16 | Per-channel received sample |
| rx_valid | output | NCH | One-cycle pulse when rx_sample updates |

## Verification
A wrong bit or slot counter shows up in the same bit period: the output-enable strobe opens one or more bit periods off its slot, and the transmit data no longer matches the expected byte order. A wrong edge choice shows up within half a bit period, because the transmit line has not yet changed when it is sampled just after the launch edge. A wrong receive shift or word-length selection stays hidden until the channel's last receive bit. It then appears as a wrong `rx_sample` or a missing valid pulse in that same frame. A missing frame-start capture appears only when the samples change mid-frame.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Serial word sent for a channel: linear words go out whole,
  // companded bytes are followed by the signalling byte.
  function automatic logic [WORD_W-1:0] pack_tx_word(input logic lin,
      input logic [WORD_W-1:0] smp, input logic [BYTE_W-1:0] sig);
    return lin ? smp : {smp[BYTE_W-1:0], sig};
  endfunction

  function automatic logic [1:0] tx_slot_count(input logic lin, input logic sig_en);
    return (lin || sig_en) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [1:0] rx_slot_count(input logic lin);
    return lin ? 2'd2 : 2'd1;
  endfunction

  // Index of the final bit in a window of nslots bytes
  function automatic logic [3:0] final_bit(input logic [1:0] nslots);
    return {nslots == 2'd2, 3'b111};
  endfunction
endpackage

// File: rtl/pcm_tsa_timing.sv
module pcm_tsa_timing #(
  parameter int SLOT_W = 7,
  parameter int OFF_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                fsync,
  input  logic                cfg_tx_fall,
  input  logic [OFF_W-1:0]    cfg_clk_slot,
  output logic                launch_edge,
  output logic                smp_edge,
  output logic                frame_start,
  output logic                frame_vld,
  output logic [SLOT_W+2:0]   fbit,
  output logic                pos_vld,
  output logic [SLOT_W-1:0]   slot,
  output logic [2:0]          bidx
);
  localparam int FBIT_W = SLOT_W + 3;
  localparam logic [FBIT_W-1:0] FBIT_MAX = '1;

  logic bclk_q;
  logic rise, fall;
  logic [FBIT_W-1:0] lpos;
  logic [FBIT_W-1:0] off_ext;

  assign rise        = bclk & ~bclk_q;
  assign fall        = ~bclk & bclk_q;
  assign launch_edge = cfg_tx_fall ? fall : rise;
  assign smp_edge    = cfg_tx_fall ? rise : fall;
  assign frame_start = launch_edge & fsync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      fbit      <= '0;
      frame_vld <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (launch_edge) begin
        if (fsync)                fbit <= '0;
        else if (fbit != FBIT_MAX) fbit <= fbit + 1'b1;
      end
      if (frame_start) frame_vld <= 1'b1;
    end
  end

  assign off_ext = FBIT_W'(cfg_clk_slot);
  assign lpos    = fbit - off_ext;
  assign pos_vld = frame_vld && (fbit >= off_ext);
  assign slot    = lpos[FBIT_W-1:3];
  assign bidx    = lpos[2:0];
endmodule

// File: rtl/pcm_tsa_chan.sv
module pcm_tsa_chan
  import pcm_tsa_pkg::*;
#(
  parameter int SLOT_W = 7,
  parameter int NHWY   = 2,
  parameter int HWY_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               smp_edge,
  input  logic               pos_vld,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [2:0]         bidx,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic               lin,
  input  logic               sig_en,
  input  logic [HWY_W-1:0]   hwy,
  input  logic [SLOT_W-1:0]  tx_base,
  input  logic [SLOT_W-1:0]  rx_base,
  input  logic [WORD_W-1:0]  tx_sample,
  input  logic [BYTE_W-1:0]  tx_sig,
  input  logic [NHWY-1:0]    hwy_rx,
  output logic               tx_own,
  output logic               tx_bit,
  output logic [WORD_W-1:0]  rx_sample,
  output logic               rx_valid
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] rx_sr;
  logic [SLOT_W:0]   tx_off, rx_off;
  logic [3:0]        tx_k, rx_k;
  logic              rx_hit, rx_last, rx_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           word_q <= '0;
    else if (frame_start) word_q <= pack_tx_word(lin, tx_sample, tx_sig);
  end

  assign tx_off = {1'b0, slot} - {1'b0, tx_base};
  assign tx_own = pos_vld && tx_en && (slot >= tx_base) &&
                  (tx_off < (SLOT_W+1)'(tx_slot_count(lin, sig_en)));
  assign tx_k   = {tx_off[0], bidx};
  assign tx_bit = tx_own & word_q[~tx_k];

  assign rx_off  = {1'b0, slot} - {1'b0, rx_base};
  assign rx_hit  = pos_vld && rx_en && (slot >= rx_base) &&
                   (rx_off < (SLOT_W+1)'(rx_slot_count(lin)));
  assign rx_k    = {rx_off[0], bidx};
  assign rx_last = (rx_k == final_bit(rx_slot_count(lin)));

  generate
    if ((1 << HWY_W) == NHWY) begin : g_rx_full
      assign rx_line = hwy_rx[hwy];
    end else begin : g_rx_guard
      assign rx_line = (int'(hwy) < NHWY) ? hwy_rx[hwy] : 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr     <= '0;
      rx_sample <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rx_hit && smp_edge) begin
        rx_sr <= {rx_sr[WORD_W-2:0], rx_line};
        if (rx_last) begin
          rx_valid  <= 1'b1;
          rx_sample <= lin ? {rx_sr[WORD_W-2:0], rx_line}
                           : {{BYTE_W{1'b0}}, rx_sr[BYTE_W-2:0], rx_line};
        end
      end
    end
  end
endmodule

// File: rtl/pcm_tsa_hwy_mux.sv
module pcm_tsa_hwy_mux #(
  parameter int NCH   = 4,
  parameter int NHWY  = 2,
  parameter int HWY_W = 1
) (
  input  logic [NCH-1:0]              tx_own,
  input  logic [NCH-1:0]              tx_bit,
  input  logic [NCH-1:0][HWY_W-1:0]   chan_hwy,
  output logic [NHWY-1:0]             hwy_tx,
  output logic [NHWY-1:0]             hwy_oe_n,
  output logic [NHWY-1:0][NCH-1:0]    grant
);
  generate
    for (genvar h = 0; h < NHWY; h++) begin : g_hwy
      logic [NCH-1:0] g;
      logic           taken;
      always_comb begin
        g     = '0;
        taken = 1'b0;
        for (int c = 0; c < NCH; c++) begin
          if (tx_own[c] && (chan_hwy[c] == HWY_W'(h)) && !taken) begin
            g[c]  = 1'b1;
            taken = 1'b1;
          end
        end
      end
      assign grant[h]    = g;
      assign hwy_tx[h]   = |(g & tx_bit);
      assign hwy_oe_n[h] = ~taken;
    end
  endgenerate
endmodule

// File: rtl/pcm_tsa.sv
module pcm_tsa
  import pcm_tsa_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NHWY   = 2,
  parameter int SLOT_W = 7,
  parameter int OFF_W  = 3,
  localparam int HWY_W = (NHWY > 1) ? $clog2(NHWY) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bclk,
  input  logic                          fsync,
  input  logic                          cfg_tx_fall,
  input  logic [OFF_W-1:0]              cfg_clk_slot,
  input  logic [NCH-1:0]                cfg_tx_en,
  input  logic [NCH-1:0]                cfg_rx_en,
  input  logic [NCH-1:0]                cfg_linear,
  input  logic [NCH-1:0]                cfg_sig_en,
  input  logic [NCH-1:0][HWY_W-1:0]     cfg_hwy,
  input  logic [NCH-1:0][SLOT_W-1:0]    cfg_tx_slot,
  input  logic [NCH-1:0][SLOT_W-1:0]    cfg_rx_slot,
  input  logic [NCH-1:0][WORD_W-1:0]    tx_sample,
  input  logic [NCH-1:0][BYTE_W-1:0]    tx_sig,
  input  logic [NHWY-1:0]               hwy_rx,
  output logic [NHWY-1:0]               hwy_tx,
  output logic [NHWY-1:0]               hwy_oe_n,
  output logic [NCH-1:0][WORD_W-1:0]    rx_sample,
  output logic [NCH-1:0]                rx_valid
);
  localparam int FBIT_W = SLOT_W + 3;

  logic                          launch_edge, smp_edge, frame_start;
  logic                          frame_vld, pos_vld;
  logic [FBIT_W-1:0]             fbit;
  logic [SLOT_W-1:0]             slot;
  logic [2:0]                    bidx;
  logic [NCH-1:0]                tx_own, tx_bit;
  logic [NHWY-1:0][NCH-1:0]      hwy_grant;

  pcm_tsa_timing #(.SLOT_W(SLOT_W), .OFF_W(OFF_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .cfg_tx_fall(cfg_tx_fall), .cfg_clk_slot(cfg_clk_slot),
    .launch_edge(launch_edge), .smp_edge(smp_edge), .frame_start(frame_start),
    .frame_vld(frame_vld), .fbit(fbit), .pos_vld(pos_vld),
    .slot(slot), .bidx(bidx)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      pcm_tsa_chan #(.SLOT_W(SLOT_W), .NHWY(NHWY), .HWY_W(HWY_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .smp_edge(smp_edge),
        .pos_vld(pos_vld), .slot(slot), .bidx(bidx),
        .tx_en(cfg_tx_en[c]), .rx_en(cfg_rx_en[c]), .lin(cfg_linear[c]),
        .sig_en(cfg_sig_en[c]), .hwy(cfg_hwy[c]),
        .tx_base(cfg_tx_slot[c]), .rx_base(cfg_rx_slot[c]),
        .tx_sample(tx_sample[c]), .tx_sig(tx_sig[c]), .hwy_rx(hwy_rx),
        .tx_own(tx_own[c]), .tx_bit(tx_bit[c]),
        .rx_sample(rx_sample[c]), .rx_valid(rx_valid[c])
      );
    end
  endgenerate

  pcm_tsa_hwy_mux #(.NCH(NCH), .NHWY(NHWY), .HWY_W(HWY_W)) u_mux (
    .tx_own(tx_own), .tx_bit(tx_bit), .chan_hwy(cfg_hwy),
    .hwy_tx(hwy_tx), .hwy_oe_n(hwy_oe_n), .grant(hwy_grant)
  );
endmodule

// File: rtl/pcm_tsa_chk.sv
module pcm_tsa_chk #(
  parameter int NCH    = 4,
  parameter int NHWY   = 2,
  parameter int SLOT_W = 7
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       fsync,
  input logic                       launch_edge,
  input logic                       smp_edge,
  input logic                       frame_vld,
  input logic [SLOT_W+2:0]          fbit,
  input logic [NHWY-1:0]            hwy_oe_n,
  input logic [NHWY-1:0][NCH-1:0]   hwy_grant,
  input logic [NCH-1:0]             rx_valid,
  input logic [NCH-1:0]             cfg_rx_en
);
  AST_IDLE_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |-> (&hwy_oe_n)); // R1

  AST_SYNC_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_edge && fsync) |=> ((fbit == '0) && frame_vld)); // R5

  AST_COUNT_HOLDS_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_edge |=> $stable(fbit)); // R6

  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> $past(smp_edge)); // R9

  generate
    for (genvar h = 0; h < NHWY; h++) begin : g_hchk
      AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hwy_grant[h])); // R8
    end
    for (genvar c = 0; c < NCH; c++) begin : g_cchk
      AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid[c] |=> !rx_valid[c]); // R9
      AST_VALID_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid[c] |-> cfg_rx_en[c]); // R10
    end
  endgenerate
endmodule

bind pcm_tsa pcm_tsa_chk #(.NCH(NCH), .NHWY(NHWY), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fsync(fsync), .launch_edge(launch_edge),
  .smp_edge(smp_edge), .frame_vld(frame_vld), .fbit(fbit),
  .hwy_oe_n(hwy_oe_n), .hwy_grant(hwy_grant), .rx_valid(rx_valid),
  .cfg_rx_en(cfg_rx_en)
);

// File: tb/pcm_tsa_bench.sv
module pcm_tsa_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4, NHWY = 2, SLOT_W = 7, OFF_W = 3, HWY_W = 1;
  localparam int FB = 128;
  localparam int HALF = 4;

  logic clk, rst_n, bclk, fsync, cfg_tx_fall;
  logic [OFF_W-1:0] cfg_clk_slot;
  logic [NCH-1:0] cfg_tx_en, cfg_rx_en, cfg_linear, cfg_sig_en;
  logic [NCH-1:0][HWY_W-1:0] cfg_hwy;
  logic [NCH-1:0][SLOT_W-1:0] cfg_tx_slot, cfg_rx_slot;
  logic [NCH-1:0][15:0] tx_sample, rx_sample;
  logic [NCH-1:0][7:0] tx_sig;
  logic [NHWY-1:0] hwy_rx, hwy_tx, hwy_oe_n;
  logic [NCH-1:0] rx_valid;

  pcm_tsa u_pcm_tsa (.*);

  int n_run = 0, n_fail = 0;
  logic [15:0] snap_s [NCH];
  logic [7:0]  snap_g [NCH];
  logic [15:0] esr [NCH];
  int          vcnt [NCH];
  logic [15:0] vdata [NCH];
  bit          mid_change;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) for (int c = 0; c < NCH; c++) if (rx_valid[c]) begin
      vcnt[c]++;
      vdata[c] = rx_sample[c];
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int tx_owner(input int h, input int f, output int k, output int ncand);
    int own = -1;
    k = 0; ncand = 0;
    for (int c = 0; c < NCH; c++) begin
      int p, s, nsl, base;
      if (!cfg_tx_en[c] || int'(cfg_hwy[c]) != h || f < int'(cfg_clk_slot)) continue;
      p = f - int'(cfg_clk_slot); s = p / 8; base = int'(cfg_tx_slot[c]);
      nsl = (cfg_linear[c] || cfg_sig_en[c]) ? 2 : 1;
      if (s >= base && s < base + nsl) begin
        ncand++;
        if (own < 0) begin own = c; k = (s - base) * 8 + p % 8; end
      end
    end
    return own;
  endfunction

  function automatic bit word_bit(input int c, input int k);
    logic [15:0] w;
    if (cfg_linear[c]) w = snap_s[c];
    else w = {snap_s[c][7:0], snap_g[c]};
    return w[15-k];
  endfunction

  task automatic check_tx(input int f, input bit second);
    for (int h = 0; h < NHWY; h++) begin
      int k, nc, own;
      bit e_oe, e_tx;
      string t;
      own  = tx_owner(h, f, k, nc);
      e_oe = (own < 0);
      e_tx = (own < 0) ? 1'b0 : word_bit(own, k);
      if (second) t = "R6 hold";
      else if (own < 0) t = "R7 idle";
      else if (nc > 1) t = "R8 priority";
      else if (cfg_linear[own]) t = "R3 linear";
      else if (k >= 8) t = "R4 signalling";
      else t = "R2 companded";
      if (own >= 0 && cfg_clk_slot != 0) t = {t, " R5"};
      if (own >= 0 && mid_change) t = {t, " R11"};
      check(hwy_oe_n[h] == e_oe && hwy_tx[h] == e_tx, t,
            {hwy_oe_n[h], hwy_tx[h]}, {e_oe, e_tx});
    end
  endtask

  task automatic rx_model(input int f, input logic [NHWY-1:0] rxb);
    for (int c = 0; c < NCH; c++) begin
      int p, s, base, nsl;
      if (!cfg_rx_en[c] || f < int'(cfg_clk_slot)) continue;
      p = f - int'(cfg_clk_slot); s = p / 8; base = int'(cfg_rx_slot[c]);
      nsl = cfg_linear[c] ? 2 : 1;
      if (s >= base && s < base + nsl) esr[c] = {esr[c][14:0], rxb[cfg_hwy[c]]};
    end
  endtask

  task automatic do_bit(input int f, input bit fs, input bit pre);
    logic [NHWY-1:0] rxb;
    @(posedge clk); #1;
    rxb = NHWY'($urandom);
    fsync = fs; hwy_rx = rxb;
    if (fs) for (int c = 0; c < NCH; c++) begin snap_s[c] = tx_sample[c]; snap_g[c] = tx_sig[c]; end
    bclk = cfg_tx_fall ? 1'b0 : 1'b1;
    if (mid_change && f == 3) begin tx_sample = {NCH{16'($urandom)}} ^ 64'($urandom); tx_sig = 32'($urandom); end
    repeat (HALF-1) @(posedge clk);
    @(negedge clk);
    if (pre) check(hwy_oe_n == '1 && hwy_tx == '0, "R1 no sync yet", {hwy_oe_n, hwy_tx}, 12);
    else check_tx(f, 1'b0);
    @(posedge clk); #1;
    bclk = ~bclk;
    repeat (HALF-1) @(posedge clk);
    @(negedge clk);
    if (!pre) begin check_tx(f, 1'b1); rx_model(f, rxb); end
  endtask

  task automatic set_fall(input bit nf);
    if (nf != cfg_tx_fall) begin
      @(posedge clk); #1;
      cfg_tx_fall = nf;
      bclk = nf ? 1'b1 : 1'b0;
      repeat (HALF) @(posedge clk);
    end
  endtask

  task automatic run_frame(input bit mid);
    mid_change = mid;
    for (int c = 0; c < NCH; c++) begin esr[c] = '0; vcnt[c] = 0; end
    tx_sample = {32'($urandom), 32'($urandom)};
    tx_sig = 32'($urandom);
    for (int f = 0; f < FB; f++) do_bit(f, f == 0, 1'b0);
    for (int c = 0; c < NCH; c++) begin
      logic [15:0] ex;
      ex = cfg_linear[c] ? esr[c] : {8'h00, esr[c][7:0]};
      if (cfg_rx_en[c]) begin
        check(vcnt[c] == 1, "R9 valid count", vcnt[c], 1);
        check(vdata[c] == ex, "R9 rx data", vdata[c], ex);
      end else check(vcnt[c] == 0, "R10 rx disabled", vcnt[c], 0);
    end
    mid_change = 1'b0;
  endtask

  task automatic rand_cfg();
    set_fall(1'($urandom));
    cfg_clk_slot = OFF_W'($urandom);
    for (int c = 0; c < NCH; c++) begin
      cfg_tx_en[c] = ($urandom % 5) != 0;
      cfg_rx_en[c] = ($urandom % 5) != 0;
      cfg_linear[c] = 1'($urandom);
      cfg_sig_en[c] = 1'($urandom);
      cfg_hwy[c] = HWY_W'($urandom);
      cfg_tx_slot[c] = SLOT_W'($urandom % 14);
      cfg_rx_slot[c] = SLOT_W'($urandom % 14);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; bclk = 0; fsync = 0; cfg_tx_fall = 0; cfg_clk_slot = '0;
    cfg_tx_en = '0; cfg_rx_en = '0; cfg_linear = '0; cfg_sig_en = '0; cfg_hwy = '0;
    cfg_tx_slot = '0; cfg_rx_slot = '0; tx_sample = '0; tx_sig = '0; hwy_rx = '0;
    mid_change = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(hwy_oe_n == '1 && hwy_tx == '0, "R1 reset lines", {hwy_oe_n, hwy_tx}, 12);
    check(rx_valid == '0 && rx_sample == '0, "R1 reset rx", rx_valid, 0);
    rst_n = 1;
    // directed frame A: rising launch, no offset, mixed codings
    cfg_tx_en = 4'b0111; cfg_rx_en = 4'b1011;
    cfg_linear = 4'b0010; cfg_sig_en = 4'b0110; cfg_hwy = 4'b0010;
    cfg_tx_slot = {7'd5, 7'd5, 7'd2, 7'd0};
    cfg_rx_slot = {7'd8, 7'd0, 7'd3, 7'd1};
    for (int i = 0; i < 20; i++) do_bit(i, 1'b0, 1'b1);
    run_frame(1'b0);
    // directed frame B: falling launch, maximum offset, collision on highway 1
    set_fall(1'b1);
    cfg_clk_slot = 3'd7;
    cfg_tx_en = 4'b1111; cfg_linear = 4'b0010; cfg_sig_en = 4'b1000; cfg_hwy = 4'b0111;
    cfg_tx_slot = {7'd0, 7'd4, 7'd13, 7'd4};
    run_frame(1'b0);
    // directed frame C: rising launch, offset 3, samples change mid-frame
    set_fall(1'b0);
    cfg_clk_slot = 3'd3;
    cfg_linear = 4'b0101; cfg_sig_en = 4'b1010;
    cfg_tx_slot = {7'd9, 7'd1, 7'd6, 7'd0};
    run_frame(1'b1);
    for (int fr = 0; fr < 45; fr++) begin
      rand_cfg();
      run_frame(fr % 3 == 0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule